// File: doc/BRIEF.md
# Staged pipeline control generator

This block produces the control for a five-stage in-order pipeline made of fetch, decode, execute, memory and write-back. During decode it turns the instruction opcode into nine control lines. The lines form three groups, one for each of the last three stages. Each group then moves down the pipeline registers on every clock edge until it reaches the stage that uses it. No central sequencer is involved. Every instruction takes the same number of cycles, so the register chain alone gives each stage the control of the instruction it is working on.

The destination register choices (the rt and rd fields) enter with the opcode. In execute, the register-destination bit picks one of them, and only that number goes on towards write-back. This way the register write at the end of the pipe is addressed by the instruction being retired. The number of whatever instruction is decoding at that time plays no part. The ALU zero flag is captured at the end of execute. In the memory stage it is combined with the branch bit to form the next-PC select. Fetch and decode need no instruction-specific control, and the pipeline registers load on every cycle.

Top module: `ctrl_stager`

## Requirements
- R1: The opcode decodes as follows, with every line not listed at 0. Opcode 0x00 (register ALU operation) gives reg_dst=1, alu_op=2'b10, reg_write=1. Opcode 0x23 (load) gives alu_src=1, mem_read=1, mem_to_reg=1, reg_write=1, alu_op=2'b00. Opcode 0x2B (store) gives alu_src=1, mem_write=1, alu_op=2'b00. Opcode 0x04 (branch on equal) gives branch=1, alu_op=2'b01.
- R2: Any other opcode decodes to all-zero control, so it passes through the pipe as a bubble that writes nothing.
- R3: The execute group (reg_dst, alu_op, alu_src) of an instruction presented in decode appears on the ex_ outputs after the next rising edge.
- R4: The memory group (branch, mem_read, mem_write) of that instruction appears on the mem_ outputs exactly one cycle after its execute group.
- R5: The write-back group (mem_to_reg, reg_write) of that instruction appears on the wb_ outputs exactly one cycle after its memory group.
- R6: wb_dest shows the rd field when the instruction's reg_dst is 1 and the rt field when it is 0. It is aligned with that instruction's write-back group.
- R7: mem_pc_src is 1 only when the memory-stage branch bit is 1 and the alu_zero value sampled while that instruction was in execute was 1. Otherwise it is 0.
- R8: A synchronous active-high reset clears every control bit in all three pipeline registers, so all control outputs read 0 after the edge.
- R9: A new instruction can enter on every cycle. The instructions in flight at the same time keep their own control and destination without interfering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_opcode | input | OPCODE_W | Opcode of the instruction in decode |
| id_rt | input | REG_W | rt register field of the instruction in decode |
| id_rd | input | REG_W | rd register field of the instruction in decode |
| alu_zero | input | 1 | ALU zero flag of the instruction in execute |
| ex_reg_dst | output | 1 | Execute stage: choose rd as destination |
| ex_alu_op | output | 2 | Execute stage: ALU operation class |
| ex_alu_src | output | 1 | Execute stage: ALU second operand is the immediate |
| mem_branch | output | 1 | Memory stage: branch-on-equal instruction |
| mem_read | output | 1 | Memory stage: data memory read |
| mem_write | output | 1 | Memory stage: data memory write |
| mem_pc_src | output | 1 | Memory stage: select the branch target as next PC |
| wb_mem_to_reg | output | 1 | Write-back stage: write memory data instead of ALU result |
| wb_reg_write | output | 1 | Write-back stage: register file write enable |
| wb_dest | output | REG_W | Write-back stage: destination register number |

## Verification
Once reset has been released, the assertions check on every cycle that each stage's group equals what the stage before it held one cycle earlier. They also check that the selected destination moves with the write-back group, that the next-PC select equals the branch bit ANDed with the zero flag captured in execute, and that at most one memory-stage action is ever active. These checks only compare neighbouring stages with each other. Whether an opcode decodes to the right values, whether an unknown opcode becomes a bubble, whether the rd/rt choice is correct, and whether back-to-back traffic keeps each instruction's destination intact can only be shown by the bench. It follows each issued instruction through the three stages and compares the outputs with values worked out from the decode table.

// File: rtl/ctrl_stage_pkg.sv
package ctrl_stage_pkg;

  localparam logic [1:0] ALUOP_ADD  = 2'b00;
  localparam logic [1:0] ALUOP_SUB  = 2'b01;
  localparam logic [1:0] ALUOP_FUNC = 2'b10;

  typedef struct packed {
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_src;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic mem_read;
    logic mem_write;
  } mem_ctl_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_write;
  } wb_ctl_t;

  localparam int EX_CTL_W  = $bits(ex_ctl_t);
  localparam int MEM_CTL_W = $bits(mem_ctl_t);
  localparam int WB_CTL_W  = $bits(wb_ctl_t);

endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_stage_pkg::*;
#(
  parameter int                    OPCODE_W = 6,
  parameter logic [OPCODE_W-1:0]   OP_ALU   = 6'h00,
  parameter logic [OPCODE_W-1:0]   OP_LOAD  = 6'h23,
  parameter logic [OPCODE_W-1:0]   OP_STORE = 6'h2b,
  parameter logic [OPCODE_W-1:0]   OP_BEQ   = 6'h04
) (
  input  logic [OPCODE_W-1:0] opcode,
  output ex_ctl_t             ex_ctl,
  output mem_ctl_t            mem_ctl,
  output wb_ctl_t             wb_ctl
);

  always_comb begin
    ex_ctl  = '0;
    mem_ctl = '0;
    wb_ctl  = '0;
    if (opcode == OP_ALU) begin
      ex_ctl.reg_dst   = 1'b1;
      ex_ctl.alu_op    = ALUOP_FUNC;
      wb_ctl.reg_write = 1'b1;
    end else if (opcode == OP_LOAD) begin
      ex_ctl.alu_src    = 1'b1;
      ex_ctl.alu_op     = ALUOP_ADD;
      mem_ctl.mem_read  = 1'b1;
      wb_ctl.mem_to_reg = 1'b1;
      wb_ctl.reg_write  = 1'b1;
    end else if (opcode == OP_STORE) begin
      ex_ctl.alu_src    = 1'b1;
      ex_ctl.alu_op     = ALUOP_ADD;
      mem_ctl.mem_write = 1'b1;
    end else if (opcode == OP_BEQ) begin
      ex_ctl.alu_op  = ALUOP_SUB;
      mem_ctl.branch = 1'b1;
    end
  end

endmodule

// File: rtl/ctrl_pipe_reg.sv
module ctrl_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/dest_select.sv
module dest_select #(
  parameter int REG_W = 5
) (
  input  logic             use_rd,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] dest
);

  assign dest = use_rd ? rd : rt;

endmodule

// File: rtl/ctrl_stager.sv
module ctrl_stager
  import ctrl_stage_pkg::*;
#(
  parameter int                    OPCODE_W = 6,
  parameter int                    REG_W    = 5,
  parameter logic [OPCODE_W-1:0]   OP_ALU   = 6'h00,
  parameter logic [OPCODE_W-1:0]   OP_LOAD  = 6'h23,
  parameter logic [OPCODE_W-1:0]   OP_STORE = 6'h2b,
  parameter logic [OPCODE_W-1:0]   OP_BEQ   = 6'h04
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OPCODE_W-1:0] id_opcode,
  input  logic [REG_W-1:0]    id_rt,
  input  logic [REG_W-1:0]    id_rd,
  input  logic                alu_zero,
  output logic                ex_reg_dst,
  output logic [1:0]          ex_alu_op,
  output logic                ex_alu_src,
  output logic                mem_branch,
  output logic                mem_read,
  output logic                mem_write,
  output logic                mem_pc_src,
  output logic                wb_mem_to_reg,
  output logic                wb_reg_write,
  output logic [REG_W-1:0]    wb_dest
);

  // Each register is narrower than the one before it: groups drop off once used.
  localparam int IDEX_W  = EX_CTL_W + MEM_CTL_W + WB_CTL_W + 2 * REG_W;
  localparam int EXMEM_W = MEM_CTL_W + WB_CTL_W + REG_W + 1;
  localparam int MEMWB_W = WB_CTL_W + REG_W;

  // decode
  ex_ctl_t  d_ex;
  mem_ctl_t d_mem;
  wb_ctl_t  d_wb;

  ctrl_decode #(
    .OPCODE_W(OPCODE_W), .OP_ALU(OP_ALU), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ)
  ) u_decode (
    .opcode (id_opcode),
    .ex_ctl (d_ex),
    .mem_ctl(d_mem),
    .wb_ctl (d_wb)
  );

  // ID/EX: all three groups plus both destination candidates
  logic [IDEX_W-1:0] idex_d, idex_q;
  ex_ctl_t           x_ex;
  mem_ctl_t          x_mem;
  wb_ctl_t           x_wb;
  logic [REG_W-1:0]  x_rt, x_rd, x_dest;

  assign idex_d = {d_ex, d_mem, d_wb, id_rt, id_rd};

  ctrl_pipe_reg #(.W(IDEX_W)) u_idex (
    .clk(clk), .rst(rst), .d(idex_d), .q(idex_q)
  );

  assign {x_ex, x_mem, x_wb, x_rt, x_rd} = idex_q;

  dest_select #(.REG_W(REG_W)) u_dest (
    .use_rd(x_ex.reg_dst), .rt(x_rt), .rd(x_rd), .dest(x_dest)
  );

  // EX/MEM: memory and write-back groups, chosen destination, zero flag
  logic [EXMEM_W-1:0] exmem_d, exmem_q;
  mem_ctl_t           m_mem;
  wb_ctl_t            m_wb;
  logic [REG_W-1:0]   m_dest;
  logic               m_zero;

  assign exmem_d = {x_mem, x_wb, x_dest, alu_zero};

  ctrl_pipe_reg #(.W(EXMEM_W)) u_exmem (
    .clk(clk), .rst(rst), .d(exmem_d), .q(exmem_q)
  );

  assign {m_mem, m_wb, m_dest, m_zero} = exmem_q;

  // MEM/WB: write-back group and destination only
  logic [MEMWB_W-1:0] memwb_d, memwb_q;
  wb_ctl_t            w_wb;
  logic [REG_W-1:0]   w_dest;

  assign memwb_d = {m_wb, m_dest};

  ctrl_pipe_reg #(.W(MEMWB_W)) u_memwb (
    .clk(clk), .rst(rst), .d(memwb_d), .q(memwb_q)
  );

  assign {w_wb, w_dest} = memwb_q;

  // stage outputs
  assign ex_reg_dst    = x_ex.reg_dst;
  assign ex_alu_op     = x_ex.alu_op;
  assign ex_alu_src    = x_ex.alu_src;
  assign mem_branch    = m_mem.branch;
  assign mem_read      = m_mem.mem_read;
  assign mem_write     = m_mem.mem_write;
  assign mem_pc_src    = m_mem.branch & m_zero;
  assign wb_mem_to_reg = w_wb.mem_to_reg;
  assign wb_reg_write  = w_wb.reg_write;
  assign wb_dest       = w_dest;

  // Goes high one edge after reset is released, so $past below sees defined state.
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_mem_follows_ex_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> ({mem_branch, mem_read, mem_write} == $past(x_mem)));

  p_wb_follows_mem_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> ({wb_mem_to_reg, wb_reg_write} == $past(m_wb)));

  p_dest_follows_r6: assert property (@(posedge clk) disable iff (rst)
    armed |-> (wb_dest == $past(x_dest, 2)) || !$past(armed));

  p_pc_src_r7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (mem_pc_src == ($past(x_mem.branch) && $past(alu_zero))));

  p_one_mem_action_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_branch, mem_read, mem_write}));

endmodule

// File: tb/test_ctrl_stager.sv
module test_ctrl_stager;

  localparam int OPCODE_W = 6;
  localparam int REG_W    = 5;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [OPCODE_W-1:0] id_opcode = '0;
  logic [REG_W-1:0]    id_rt = '0;
  logic [REG_W-1:0]    id_rd = '0;
  logic                alu_zero = 1'b0;
  logic                ex_reg_dst, ex_alu_src, mem_branch, mem_read, mem_write;
  logic                mem_pc_src, wb_mem_to_reg, wb_reg_write;
  logic [1:0]          ex_alu_op;
  logic [REG_W-1:0]    wb_dest;

  always #10 clk = ~clk;  // 50 MHz

  ctrl_stager i_ctrl_stager (
    .clk(clk), .rst(rst), .id_opcode(id_opcode), .id_rt(id_rt), .id_rd(id_rd),
    .alu_zero(alu_zero), .ex_reg_dst(ex_reg_dst), .ex_alu_op(ex_alu_op),
    .ex_alu_src(ex_alu_src), .mem_branch(mem_branch), .mem_read(mem_read),
    .mem_write(mem_write), .mem_pc_src(mem_pc_src), .wb_mem_to_reg(wb_mem_to_reg),
    .wb_reg_write(wb_reg_write), .wb_dest(wb_dest)
  );

  typedef struct {
    logic [3:0]       ex;    // reg_dst, alu_op[1:0], alu_src
    logic [2:0]       mem;   // branch, mem_read, mem_write
    logic [1:0]       wb;    // mem_to_reg, reg_write
    logic             pc_src;
    logic [REG_W-1:0] dest;
  } exp_t;

  exp_t exq[$];
  int   errors = 0;
  int   checks = 0;
  logic prev_zero = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected values straight from the R1/R2/R6/R7 decode table
  function automatic exp_t model(input logic [5:0] op, input logic [4:0] rt,
                                 input logic [4:0] rd, input logic zero);
    exp_t e;
    e.ex = 4'b0; e.mem = 3'b0; e.wb = 2'b0;
    case (op)
      6'h00: begin e.ex = 4'b1100; e.wb = 2'b01; end
      6'h23: begin e.ex = 4'b0001; e.mem = 3'b010; e.wb = 2'b11; end
      6'h2b: begin e.ex = 4'b0001; e.mem = 3'b001; end
      6'h04: begin e.ex = 4'b0010; e.mem = 3'b100; end
      default: ;
    endcase
    e.dest   = e.ex[3] ? rd : rt;
    e.pc_src = e.mem[2] & zero;
    return e;
  endfunction

  // Driver: issue at the falling edge; the zero flag for the previous one goes out now.
  task automatic issue(input logic [5:0] op, input logic [4:0] rt,
                       input logic [4:0] rd, input logic zero);
    @(negedge clk);
    rst       = 1'b0;
    id_opcode = op;
    id_rt     = rt;
    id_rd     = rd;
    alu_zero  = prev_zero;
    prev_zero = zero;
    exq.push_back(model(op, rt, rd, zero));
  endtask

  // Monitor: steps expected items through three stages, samples 2 ns after the edge
  exp_t cex, cmem, cwb;
  bit   vex = 0, vmem = 0, vwb = 0;
  always @(posedge clk) begin
    automatic logic rst_s = rst;
    #2;
    if (rst_s) begin
      vex = 0; vmem = 0; vwb = 0;
      exq.delete();
      chk({ex_reg_dst, ex_alu_op, ex_alu_src, mem_branch, mem_read, mem_write,
           mem_pc_src, wb_mem_to_reg, wb_reg_write} == 11'b0,
          "R8 reset clears control",
          {ex_reg_dst, ex_alu_op, ex_alu_src, mem_branch, mem_read, mem_write,
           mem_pc_src, wb_mem_to_reg, wb_reg_write}, 0);
    end else begin
      cwb = cmem; vwb = vmem;
      cmem = cex; vmem = vex;
      if (exq.size() > 0) begin cex = exq.pop_front(); vex = 1; end
      else vex = 0;
      if (vex)
        chk({ex_reg_dst, ex_alu_op, ex_alu_src} == cex.ex, "R1/R2/R3 execute group",
            {ex_reg_dst, ex_alu_op, ex_alu_src}, cex.ex);
      if (vmem) begin
        chk({mem_branch, mem_read, mem_write} == cmem.mem, "R4 memory group",
            {mem_branch, mem_read, mem_write}, cmem.mem);
        chk(mem_pc_src == cmem.pc_src, "R7 next-PC select", mem_pc_src, cmem.pc_src);
      end
      if (vwb) begin
        chk({wb_mem_to_reg, wb_reg_write} == cwb.wb, "R5 write-back group",
            {wb_mem_to_reg, wb_reg_write}, cwb.wb);
        chk(wb_dest == cwb.dest, "R6/R9 destination", wb_dest, cwb.dest);
      end
    end
  end

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);          // R8 checked by monitor during reset
    issue(6'h00, 5'd7, 5'd3, 1'b0);     // R1 register op: dest rd
    issue(6'h23, 5'd9, 5'd1, 1'b0);     // R1 load: dest rt
    issue(6'h2b, 5'd4, 5'd5, 1'b0);     // R1 store
    issue(6'h04, 5'd2, 5'd6, 1'b1);     // R7 taken branch
    issue(6'h04, 5'd2, 5'd6, 1'b0);     // R7 not taken
    issue(6'h00, 5'd8, 5'd11, 1'b1);    // R7 zero without branch
    issue(6'h3f, 5'd12, 5'd13, 1'b1);   // R2 unknown opcode
    issue(6'h08, 5'd14, 5'd15, 1'b0);   // R2 unknown opcode
    // R9 back-to-back mix with varying fields
    for (int i = 0; i < 40; i++) begin
      automatic logic [5:0] op;
      case (i % 5)
        0: op = 6'h00;
        1: op = 6'h23;
        2: op = 6'h2b;
        3: op = 6'h04;
        default: op = 6'h11;
      endcase
      issue(op, 5'(i * 3 + 1), 5'(31 - i), 1'(i / 2));
    end
    // R8 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    prev_zero = 1'b0;
    repeat (2) @(negedge clk);
    issue(6'h23, 5'd30, 5'd29, 1'b0);
    issue(6'h04, 5'd0, 5'd0, 1'b1);
    issue(6'h00, 5'd1, 5'd31, 1'b0);
    for (int i = 0; i < 4; i++) issue(6'h3f, 5'd0, 5'd0, 1'b0);
    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule